// File: doc/BRIEF.md
# DSP Operand and Accumulator Register Bank

This block is the register bank at the heart of a fixed-point DSP data path. It keeps four 16-bit operand words and two 40-bit accumulators. Each accumulator is made of three parts: an 8-bit guard extension, a 16-bit upper word and a 16-bit lower word. The operand words are also presented in pairs as two 32-bit sources. The accumulators are presented whole as 40-bit sources. A 16-bit multiplier operand is always taken from the upper word of one accumulator.

Writes reach the bank from three places:

- A 16-bit data bus, which can reach every part.
- A narrower global bus, which reaches only the operand words and the two accumulator upper words.
- A result port, which loads a full 40-bit accumulator from the arithmetic unit.

All reads are taken from the registered state. A value loaded in a cycle is therefore seen from the next cycle on, and the current operation keeps using the old contents.

Top module: `dsp_regbank`

## Requirements
- R1: Register select codes are 0 X0, 1 X1, 2 Y0, 3 Y1, 4 A0 (A lower), 5 A1 (A upper), 6 A2 (A extension), 7 B0, 8 B1, 9 B2, 10 A whole, 11 B whole. A data-bus word write to codes 0..3 stores the word. The pair outputs are `x_pair` = {X1,X0} and `y_pair` = {Y1,Y0}, and a data-bus read of codes 0..3 returns the stored word.
- R2: A result write loads all 40 bits {ext,upper,lower} of the accumulator picked by `res_wr_acc` (0 = A, 1 = B) in one cycle. `acc_a` and `acc_b` present the accumulators as {ext[7:0], upper[15:0], lower[15:0]}.
- R3: A data-bus read of an extension (code 6 or 9) returns the 8 bits in bits 7..0, and bits 15..8 are copies of bit 7.
- R4: A data-bus write to an extension (code 6 or 9) stores bits 7..0 of the word, and bits 15..8 of the word have no effect.
- R5: The global bus reads and writes only codes 0, 1, 2, 3, 5 and 8. Global reads of any other code return zero, and global writes to them change nothing.
- R6: `mul_op` is the upper word of accumulator A when `mul_sel` is 0, and of B when it is 1.
- R7: A data-bus write to code 10 or 11 stores the word in the upper part, fills the extension with the word's bit 15 and clears the lower part. A data-bus read of code 10 or 11 returns the upper word.
- R8: Reads in a cycle return the value held before that cycle's write. The written value is visible from the next cycle.
- R9: Writes to the same part in one cycle are resolved as result port over data bus over global bus. Writes to different parts in one cycle all take effect.
- R10: A synchronous active-high reset clears every register to zero.
- R11: Codes 12..15 read as zero on the data bus, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| db_rd_sel | input | 4 | Data-bus read select code |
| db_rd_data | output | 16 | Data-bus read word |
| db_wr_en | input | 1 | Data-bus write strobe |
| db_wr_sel | input | 4 | Data-bus write select code |
| db_wr_data | input | 16 | Data-bus write word |
| gb_rd_sel | input | 4 | Global-bus read select code |
| gb_rd_data | output | 16 | Global-bus read word |
| gb_wr_en | input | 1 | Global-bus write strobe |
| gb_wr_sel | input | 4 | Global-bus write select code |
| gb_wr_data | input | 16 | Global-bus write word |
| res_wr_en | input | 1 | Result write strobe |
| res_wr_acc | input | 1 | Result target, 0 = A, 1 = B |
| res_wr_data | input | 40 | Full accumulator result |
| x_pair | output | 32 | {X1,X0} |
| y_pair | output | 32 | {Y1,Y0} |
| acc_a | output | 40 | Accumulator A source |
| acc_b | output | 40 | Accumulator B source |
| mul_sel | input | 1 | Multiplier operand source, 0 = A, 1 = B |
| mul_op | output | 16 | Upper word of the selected accumulator |

## Verification
The bench reads back an extension holding 0x80 and checks for the 0xFF80 pattern. A bank that zero-filled the top byte would return 0x0080 there, and one that stored the whole word on an extension write would leak the top byte into the 40-bit source. Whole-accumulator writes use a negative word: a missing sign fill or a lower word that was left in place shows up as a wrong `acc_a`. The global bus is aimed at the extension and lower-word codes. A bank that did not enforce the restriction would alter the accumulator or return nonzero data. Simultaneous writes from all three sources check the priority order, and a write paired with a same-cycle read checks that no write data is forwarded early.

// File: rtl/dsp_regbank_pkg.sv
package dsp_regbank_pkg;
    localparam int WORD_W  = 16;
    localparam int EXT_W   = 8;
    localparam int NUM_OPR = 4;
    localparam int NUM_ACC = 2;
    localparam int SEL_W   = 4;
    localparam int ACC_W   = EXT_W + 2 * WORD_W;
    localparam int PAIR_W  = 2 * WORD_W;

    localparam logic [SEL_W-1:0] SEL_X0 = 4'd0;
    localparam logic [SEL_W-1:0] SEL_X1 = 4'd1;
    localparam logic [SEL_W-1:0] SEL_Y0 = 4'd2;
    localparam logic [SEL_W-1:0] SEL_Y1 = 4'd3;
    localparam logic [SEL_W-1:0] SEL_A0 = 4'd4;
    localparam logic [SEL_W-1:0] SEL_A1 = 4'd5;
    localparam logic [SEL_W-1:0] SEL_A2 = 4'd6;
    localparam logic [SEL_W-1:0] SEL_B0 = 4'd7;
    localparam logic [SEL_W-1:0] SEL_B1 = 4'd8;
    localparam logic [SEL_W-1:0] SEL_B2 = 4'd9;
    localparam logic [SEL_W-1:0] SEL_AW = 4'd10;
    localparam logic [SEL_W-1:0] SEL_BW = 4'd11;

    typedef struct packed {
        logic [NUM_OPR-1:0][WORD_W-1:0] opr;
        logic [NUM_ACC-1:0][EXT_W-1:0]  ext;
        logic [NUM_ACC-1:0][WORD_W-1:0] msp;
        logic [NUM_ACC-1:0][WORD_W-1:0] lsp;
    } bank_t;

    typedef struct packed {
        logic [NUM_OPR-1:0] opr_we;
        logic [NUM_ACC-1:0] ext_we;
        logic [NUM_ACC-1:0] msp_we;
        logic [NUM_ACC-1:0] lsp_we;
        logic [WORD_W-1:0]  word;
        logic [EXT_W-1:0]   ext_val;
        logic [WORD_W-1:0]  lsp_val;
    } wreq_t;
endpackage

// File: rtl/dsp_regbank_wdec.sv
module dsp_regbank_wdec
    import dsp_regbank_pkg::*;
#(
    parameter bit GLOBAL_ONLY = 1'b0
) (
    input  logic              en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] data,
    output wreq_t             req
);
    always_comb begin
        req         = '0;
        req.word    = data;
        req.lsp_val = data;
        req.ext_val = data[EXT_W-1:0];
        if (en) begin
            case (sel)
                SEL_X0: req.opr_we[0] = 1'b1;
                SEL_X1: req.opr_we[1] = 1'b1;
                SEL_Y0: req.opr_we[2] = 1'b1;
                SEL_Y1: req.opr_we[3] = 1'b1;
                SEL_A1: req.msp_we[0] = 1'b1;
                SEL_B1: req.msp_we[1] = 1'b1;
                SEL_A0: req.lsp_we[0] = !GLOBAL_ONLY;
                SEL_B0: req.lsp_we[1] = !GLOBAL_ONLY;
                SEL_A2: req.ext_we[0] = !GLOBAL_ONLY;
                SEL_B2: req.ext_we[1] = !GLOBAL_ONLY;
                SEL_AW, SEL_BW: begin
                    req.ext_we[sel == SEL_BW] = !GLOBAL_ONLY;
                    req.msp_we[sel == SEL_BW] = !GLOBAL_ONLY;
                    req.lsp_we[sel == SEL_BW] = !GLOBAL_ONLY;
                    req.lsp_val = '0;
                    req.ext_val = {EXT_W{data[WORD_W-1]}};
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dsp_regbank_rmux.sv
module dsp_regbank_rmux
    import dsp_regbank_pkg::*;
#(
    parameter bit GLOBAL_ONLY = 1'b0
) (
    input  bank_t             bank,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] data
);
    localparam int FILL_W = WORD_W - EXT_W;

    logic [WORD_W-1:0] ext_a_word;
    logic [WORD_W-1:0] ext_b_word;

    assign ext_a_word = {{FILL_W{bank.ext[0][EXT_W-1]}}, bank.ext[0]};
    assign ext_b_word = {{FILL_W{bank.ext[1][EXT_W-1]}}, bank.ext[1]};

    always_comb begin
        data = '0;
        case (sel)
            SEL_X0: data = bank.opr[0];
            SEL_X1: data = bank.opr[1];
            SEL_Y0: data = bank.opr[2];
            SEL_Y1: data = bank.opr[3];
            SEL_A1: data = bank.msp[0];
            SEL_B1: data = bank.msp[1];
            SEL_A0: if (!GLOBAL_ONLY) data = bank.lsp[0];
            SEL_B0: if (!GLOBAL_ONLY) data = bank.lsp[1];
            SEL_A2: if (!GLOBAL_ONLY) data = ext_a_word;
            SEL_B2: if (!GLOBAL_ONLY) data = ext_b_word;
            SEL_AW: if (!GLOBAL_ONLY) data = bank.msp[0];
            SEL_BW: if (!GLOBAL_ONLY) data = bank.msp[1];
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/dsp_regbank.sv
module dsp_regbank
    import dsp_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  db_rd_sel,
    output logic [WORD_W-1:0] db_rd_data,
    input  logic              db_wr_en,
    input  logic [SEL_W-1:0]  db_wr_sel,
    input  logic [WORD_W-1:0] db_wr_data,
    input  logic [SEL_W-1:0]  gb_rd_sel,
    output logic [WORD_W-1:0] gb_rd_data,
    input  logic              gb_wr_en,
    input  logic [SEL_W-1:0]  gb_wr_sel,
    input  logic [WORD_W-1:0] gb_wr_data,
    input  logic              res_wr_en,
    input  logic              res_wr_acc,
    input  logic [ACC_W-1:0]  res_wr_data,
    output logic [PAIR_W-1:0] x_pair,
    output logic [PAIR_W-1:0] y_pair,
    output logic [ACC_W-1:0]  acc_a,
    output logic [ACC_W-1:0]  acc_b,
    input  logic              mul_sel,
    output logic [WORD_W-1:0] mul_op
);
    localparam int NUM_BUS = 2;

    bank_t bank_d;
    bank_t bank_q;
    wreq_t req [NUM_BUS];

    // index 0: global bus (lowest priority), index 1: data bus
    dsp_regbank_wdec #(.GLOBAL_ONLY(1'b1)) i_gb_wdec (
        .en(gb_wr_en), .sel(gb_wr_sel), .data(gb_wr_data), .req(req[0])
    );
    dsp_regbank_wdec #(.GLOBAL_ONLY(1'b0)) i_db_wdec (
        .en(db_wr_en), .sel(db_wr_sel), .data(db_wr_data), .req(req[1])
    );

    dsp_regbank_rmux #(.GLOBAL_ONLY(1'b0)) i_db_rmux (
        .bank(bank_q), .sel(db_rd_sel), .data(db_rd_data)
    );
    dsp_regbank_rmux #(.GLOBAL_ONLY(1'b1)) i_gb_rmux (
        .bank(bank_q), .sel(gb_rd_sel), .data(gb_rd_data)
    );

    always_comb begin
        bank_d = bank_q;
        for (int p = 0; p < NUM_BUS; p++) begin
            for (int r = 0; r < NUM_OPR; r++) begin
                if (req[p].opr_we[r]) bank_d.opr[r] = req[p].word;
            end
            for (int a = 0; a < NUM_ACC; a++) begin
                if (req[p].ext_we[a]) bank_d.ext[a] = req[p].ext_val;
                if (req[p].msp_we[a]) bank_d.msp[a] = req[p].word;
                if (req[p].lsp_we[a]) bank_d.lsp[a] = req[p].lsp_val;
            end
        end
        if (res_wr_en) begin
            {bank_d.ext[res_wr_acc], bank_d.msp[res_wr_acc], bank_d.lsp[res_wr_acc]} = res_wr_data;
        end
        if (rst) bank_d = '0;
    end

    always_ff @(posedge clk) begin
        bank_q <= bank_d;
    end

    assign x_pair = {bank_q.opr[1], bank_q.opr[0]};
    assign y_pair = {bank_q.opr[3], bank_q.opr[2]};
    assign acc_a  = {bank_q.ext[0], bank_q.msp[0], bank_q.lsp[0]};
    assign acc_b  = {bank_q.ext[1], bank_q.msp[1], bank_q.lsp[1]};
    assign mul_op = bank_q.msp[mul_sel];
endmodule

// File: rtl/dsp_regbank_chk.sv
module dsp_regbank_chk
    import dsp_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  db_rd_sel,
    input logic [WORD_W-1:0] db_rd_data,
    input logic              db_wr_en,
    input logic [SEL_W-1:0]  db_wr_sel,
    input logic [WORD_W-1:0] db_wr_data,
    input logic [SEL_W-1:0]  gb_rd_sel,
    input logic [WORD_W-1:0] gb_rd_data,
    input logic              res_wr_en,
    input logic              res_wr_acc,
    input logic [ACC_W-1:0]  res_wr_data,
    input logic [PAIR_W-1:0] x_pair,
    input logic [PAIR_W-1:0] y_pair,
    input logic [ACC_W-1:0]  acc_a,
    input logic [ACC_W-1:0]  acc_b,
    input logic              mul_sel,
    input logic [WORD_W-1:0] mul_op
);
    AST_PAIR_UPPER: assert property (@(posedge clk) disable iff (rst)
        (db_rd_sel == SEL_X1) |-> (db_rd_data == x_pair[PAIR_W-1:WORD_W])); // R1

    AST_RESULT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (res_wr_en && !res_wr_acc) |=> (acc_a == $past(res_wr_data))); // R2

    AST_EXT_SIGN_READ: assert property (@(posedge clk) disable iff (rst)
        (db_rd_sel == SEL_A2) |->
        (db_rd_data == {{(WORD_W-EXT_W){acc_a[ACC_W-1]}}, acc_a[ACC_W-1 -: EXT_W]})); // R3

    AST_GLOBAL_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (gb_rd_sel > SEL_Y1 && gb_rd_sel != SEL_A1 && gb_rd_sel != SEL_B1) |->
        (gb_rd_data == '0)); // R5

    AST_MUL_UPPER: assert property (@(posedge clk) disable iff (rst)
        mul_op == (mul_sel ? acc_b[ACC_W-EXT_W-1 -: WORD_W] : acc_a[ACC_W-EXT_W-1 -: WORD_W])); // R6

    AST_WHOLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (db_wr_en && db_wr_sel == SEL_AW && !(res_wr_en && !res_wr_acc)) |=>
        (acc_a == {{EXT_W{$past(db_wr_data[WORD_W-1])}}, $past(db_wr_data), {WORD_W{1'b0}}})); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (x_pair == '0 && y_pair == '0 && acc_a == '0 && acc_b == '0)); // R10

    AST_UNUSED_READ: assert property (@(posedge clk) disable iff (rst)
        (db_rd_sel > SEL_BW) |-> (db_rd_data == '0)); // R11
endmodule

bind dsp_regbank dsp_regbank_chk i_dsp_regbank_chk (.*);

// File: tb/test_dsp_regbank.sv
`timescale 1ns/1ps
module test_dsp_regbank;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  db_rd_sel, db_wr_sel, gb_rd_sel, gb_wr_sel;
    logic [15:0] db_rd_data, gb_rd_data, db_wr_data, gb_wr_data, mul_op;
    logic        db_wr_en, gb_wr_en, res_wr_en, res_wr_acc, mul_sel;
    logic [39:0] res_wr_data, acc_a, acc_b;
    logic [31:0] x_pair, y_pair;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dsp_regbank i_dsp_regbank (
        .clk(clk), .rst(rst),
        .db_rd_sel(db_rd_sel), .db_rd_data(db_rd_data),
        .db_wr_en(db_wr_en), .db_wr_sel(db_wr_sel), .db_wr_data(db_wr_data),
        .gb_rd_sel(gb_rd_sel), .gb_rd_data(gb_rd_data),
        .gb_wr_en(gb_wr_en), .gb_wr_sel(gb_wr_sel), .gb_wr_data(gb_wr_data),
        .res_wr_en(res_wr_en), .res_wr_acc(res_wr_acc), .res_wr_data(res_wr_data),
        .x_pair(x_pair), .y_pair(y_pair), .acc_a(acc_a), .acc_b(acc_b),
        .mul_sel(mul_sel), .mul_op(mul_op)
    );

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic db_wr(input logic [3:0] s, input logic [15:0] d);
        @(negedge clk);
        db_wr_en = 1'b1; db_wr_sel = s; db_wr_data = d;
        @(negedge clk);
        db_wr_en = 1'b0;
    endtask

    task automatic gb_wr(input logic [3:0] s, input logic [15:0] d);
        @(negedge clk);
        gb_wr_en = 1'b1; gb_wr_sel = s; gb_wr_data = d;
        @(negedge clk);
        gb_wr_en = 1'b0;
    endtask

    task automatic res_wr(input logic acc, input logic [39:0] d);
        @(negedge clk);
        res_wr_en = 1'b1; res_wr_acc = acc; res_wr_data = d;
        @(negedge clk);
        res_wr_en = 1'b0;
    endtask

    task automatic db_rd_chk(input string req, input logic [3:0] s, input logic [15:0] exp);
        db_rd_sel = s; #0.5;
        chk(req, {24'h0, db_rd_data}, {24'h0, exp});
    endtask

    task automatic gb_rd_chk(input string req, input logic [3:0] s, input logic [15:0] exp);
        gb_rd_sel = s; #0.5;
        chk(req, {24'h0, gb_rd_data}, {24'h0, exp});
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R10 x_pair after reset", {8'h0, x_pair}, 40'h0);
        chk("R10 y_pair after reset", {8'h0, y_pair}, 40'h0);
        chk("R10 acc_a after reset", acc_a, 40'h0);
        chk("R10 acc_b after reset", acc_b, 40'h0);
    endtask

    task automatic t_operands();
        db_wr(4'd0, 16'h0102); db_wr(4'd1, 16'h0304);
        db_wr(4'd2, 16'h0506); db_wr(4'd3, 16'h8708);
        chk("R1 x_pair", {8'h0, x_pair}, 40'h0003040102);
        chk("R1 y_pair", {8'h0, y_pair}, 40'h0087080506);
        db_rd_chk("R1 read X1", 4'd1, 16'h0304);
        db_rd_chk("R1 read Y0", 4'd2, 16'h0506);
    endtask

    task automatic t_result();
        res_wr(1'b0, 40'h80_1234_5678);
        res_wr(1'b1, 40'h7F_8765_4321);
        chk("R2 result into A", acc_a, 40'h80_1234_5678);
        chk("R2 result into B", acc_b, 40'h7F_8765_4321);
    endtask

    task automatic t_ext();
        db_rd_chk("R3 negative extension read", 4'd6, 16'hFF80);
        db_rd_chk("R3 positive extension read", 4'd9, 16'h007F);
        db_wr(4'd6, 16'h127F);
        chk("R4 extension write keeps low byte", acc_a, 40'h7F_1234_5678);
        db_rd_chk("R4 extension read back", 4'd6, 16'h007F);
    endtask

    task automatic t_global();
        gb_wr(4'd5, 16'hCAFE);
        chk("R5 global write A1", acc_a, 40'h7F_CAFE_5678);
        gb_wr(4'd4, 16'h0000);
        gb_wr(4'd6, 16'h0001);
        chk("R5 global write A0/A2 ignored", acc_a, 40'h7F_CAFE_5678);
        gb_rd_chk("R5 global read A2 blocked", 4'd6, 16'h0000);
        gb_rd_chk("R5 global read A0 blocked", 4'd4, 16'h0000);
        gb_rd_chk("R5 global read Y1", 4'd3, 16'h8708);
        gb_rd_chk("R5 global read B1", 4'd8, 16'h8765);
    endtask

    task automatic t_mul();
        mul_sel = 1'b0; #0.5;
        chk("R6 mul operand from A", {24'h0, mul_op}, {24'h0, 16'hCAFE});
        mul_sel = 1'b1; #0.5;
        chk("R6 mul operand from B", {24'h0, mul_op}, {24'h0, 16'h8765});
    endtask

    task automatic t_whole();
        db_wr(4'd10, 16'h8001);
        chk("R7 whole write negative into A", acc_a, 40'hFF_8001_0000);
        db_rd_chk("R7 whole read A", 4'd10, 16'h8001);
        db_wr(4'd11, 16'h1234);
        chk("R7 whole write positive into B", acc_b, 40'h00_1234_0000);
    endtask

    task automatic t_read_old();
        @(negedge clk);
        db_wr_en = 1'b1; db_wr_sel = 4'd0; db_wr_data = 16'hBEEF; db_rd_sel = 4'd0;
        #0.5;
        chk("R8 same-cycle read sees old", {24'h0, db_rd_data}, {24'h0, 16'h0102});
        chk("R8 pair still old", {8'h0, x_pair}, 40'h0003040102);
        @(negedge clk);
        db_wr_en = 1'b0;
        chk("R8 new value next cycle", {24'h0, db_rd_data}, {24'h0, 16'hBEEF});
    endtask

    task automatic t_priority();
        @(negedge clk);
        res_wr_en = 1'b1; res_wr_acc = 1'b0; res_wr_data = 40'h11_2222_3333;
        db_wr_en = 1'b1; db_wr_sel = 4'd5; db_wr_data = 16'hAAAA;
        gb_wr_en = 1'b1; gb_wr_sel = 4'd5; gb_wr_data = 16'hBBBB;
        @(negedge clk);
        res_wr_en = 1'b0;
        chk("R9 result beats buses", acc_a, 40'h11_2222_3333);
        db_wr_sel = 4'd0; db_wr_data = 16'h1111;
        gb_wr_sel = 4'd0; gb_wr_data = 16'h2222;
        @(negedge clk);
        chk("R9 data bus beats global bus", {8'h0, x_pair}, 40'h0003041111);
        db_wr_sel = 4'd1; db_wr_data = 16'h5555;
        gb_wr_sel = 4'd2; gb_wr_data = 16'h6666;
        @(negedge clk);
        db_wr_en = 1'b0; gb_wr_en = 1'b0;
        chk("R9 distinct targets X1", {8'h0, x_pair}, 40'h0055551111);
        chk("R9 distinct targets Y0", {8'h0, y_pair}, 40'h0087086666);
    endtask

    task automatic t_unused();
        db_wr(4'd13, 16'hFFFF);
        db_wr(4'd15, 16'h8000);
        gb_wr(4'd14, 16'hFFFF);
        chk("R11 unused write x_pair", {8'h0, x_pair}, 40'h0055551111);
        chk("R11 unused write y_pair", {8'h0, y_pair}, 40'h0087086666);
        chk("R11 unused write acc_a", acc_a, 40'h11_2222_3333);
        chk("R11 unused write acc_b", acc_b, 40'h00_1234_0000);
        db_rd_chk("R11 unused read zero", 4'd13, 16'h0000);
        gb_rd_chk("R11 unused global read zero", 4'd15, 16'h0000);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset clears acc_a", acc_a, 40'h0);
        chk("R10 reset clears acc_b", acc_b, 40'h0);
        chk("R10 reset clears x_pair", {8'h0, x_pair}, 40'h0);
        chk("R10 reset clears y_pair", {8'h0, y_pair}, 40'h0);
    endtask

    initial begin
        rst = 1'b1;
        db_rd_sel = '0; db_wr_sel = '0; gb_rd_sel = '0; gb_wr_sel = '0;
        db_wr_data = '0; gb_wr_data = '0; res_wr_data = '0;
        db_wr_en = 1'b0; gb_wr_en = 1'b0; res_wr_en = 1'b0; res_wr_acc = 1'b0; mul_sel = 1'b0;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_operands();
        t_result();
        t_ext();
        t_global();
        t_mul();
        t_whole();
        t_read_old();
        t_priority();
        t_unused();
        t_reset_again();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule